// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects a set of peripheral interrupt inputs and forwards them to a parent interrupt controller as one cascade request. Each input can be programmed for level or edge sensing and for either polarity, giving four detection modes: level-high, level-low, rising and falling. A line that is both pending and unmasked shows in a status word. The cascade output is high while that status word is nonzero.

Software uses a simple synchronous register bus. The mask cannot be written as a whole word. Bits are set through one strobe register and cleared through another, so a read-modify-write race between two agents cannot arise. Edge-latched pending state is cleared through a write-one-to-clear register. A vector register returns the index of the lowest pending line, so the handler does not have to scan the bits itself.

Register offsets are word addresses on `addr_i`. Any address whose upper bits above bit 2 are not zero is unmapped: writes to it do nothing and reads return zero. Read data is registered. It appears on `rdata_o` after the clock edge at which `re_i` is high, and it holds until the next read.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: A write to offset 1 sets each mask bit whose write-data bit is 1 and leaves every other mask bit unchanged.
- R2: A write to offset 2 clears each mask bit whose write-data bit is 1 and leaves every other mask bit unchanged.
- R3: Reading offset 0 returns the current mask. A write to offset 0 has no effect on the mask.
- R4: Offset 3 is a read/write sense register. A bit value of 1 makes that line edge-sensitive and 0 makes it level-sensitive.
- R5: Offset 4 is a read/write polarity register. A bit value of 1 selects active-low (level) or falling (edge), and 0 selects active-high or rising.
- R6: An edge line stays pending after its input returns to idle. It is cleared only by writing 1 to its bit at offset 5.
- R7: Reading offset 6 returns pending AND mask. `cascade_o` is high exactly when that value is nonzero.
- R8: Each input passes through a two-flop synchronizer. A change on an input shows in status and on `cascade_o` after the third rising clock edge, and not before.
- R9: A level line's pending bit follows its polarity-qualified input. A write to offset 5 does not clear it while the input stays active.
- R10: Reading offset 7 returns the index of the lowest set status bit in the low bits, or 0x8000_0000 when status is zero.
- R11: When a selected edge is detected in the same cycle as a clear write for that line, the line stays pending.
- R12: After reset, the mask, sense, polarity and pending bits are all zero, the vector reads 0x8000_0000 and `cascade_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_LINES | Asynchronous peripheral interrupt inputs |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| cascade_o | output | 1 | Request to the parent controller |

## Verification
The hardest case to reach from the ports is a clear write that lands in exactly the cycle in which a new edge is detected for the same line. That cycle lies three clock edges after the input pin changes, behind the synchronizer. The bench drives the input on a falling clock edge and counts two more falling edges. It then issues the clear write so that it commits at the edge where the edge detector fires, and reads status to confirm the line is still pending. The sweep through the stimulus table lets its own configuration changes settle and flushes any pending state they cause before each measured input change. As a result, every expected status value depends only on the programmed mode and the two input patterns.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] OFF_EN       = 3'd0;
  localparam logic [REG_AW-1:0] OFF_EN_SET   = 3'd1;
  localparam logic [REG_AW-1:0] OFF_EN_CLR   = 3'd2;
  localparam logic [REG_AW-1:0] OFF_SENSE    = 3'd3;
  localparam logic [REG_AW-1:0] OFF_POL      = 3'd4;
  localparam logic [REG_AW-1:0] OFF_PEND_CLR = 3'd5;
  localparam logic [REG_AW-1:0] OFF_STATUS   = 3'd6;
  localparam logic [REG_AW-1:0] OFF_VECTOR   = 3'd7;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/irq_line_detect.sv
module irq_line_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] sense_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    logic rise, fall, hit, lvl;
    // edges come from raw synced samples so a polarity write makes no edge
    assign rise = sync_i[g] & ~prev_q[g];
    assign fall = ~sync_i[g] & prev_q[g];
    assign hit  = pol_i[g] ? fall : rise;
    assign lvl  = sync_i[g] ^ pol_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pend_q[g] <= 1'b0;
      else if (sense_i[g]) pend_q[g] <= hit | (pend_q[g] & ~clr_i[g]); // R11: edge beats clear
      else                 pend_q[g] <= lvl;                           // R9
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N      = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic [N-1:0]      status_i,
  output logic [DATA_W-1:0] vec_o
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (status_i[i]) idx = IDX_W'(i);
    end
  end

  // R10
  always_comb begin
    vec_o = '0;
    if (|status_i) vec_o[IDX_W-1:0] = idx;
    else           vec_o[DATA_W-1] = 1'b1;
  end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_cascade_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      status_i,
  input  logic [DATA_W-1:0] vec_i,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      sense_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N-1:0]      en_q, sense_q, pol_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              hit;
  logic [REG_AW-1:0] off;
  logic [N-1:0]      wbits;

  assign off   = addr_i[REG_AW-1:0];
  assign wbits = wdata_i[N-1:0];

  if (ADDR_W > REG_AW) begin : g_hi
    assign hit = (addr_i[ADDR_W-1:REG_AW] == '0);
  end else begin : g_nohi
    assign hit = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      sense_q <= '0;
      pol_q   <= '0;
    end else if (we_i && hit) begin
      case (off)
        OFF_EN_SET: en_q    <= en_q | wbits;   // R1
        OFF_EN_CLR: en_q    <= en_q & ~wbits;  // R2
        OFF_SENSE:  sense_q <= wbits;          // R4
        OFF_POL:    pol_q   <= wbits;          // R5
        default: ;                             // R3: offset 0 read-only
      endcase
    end
  end

  assign clr_o = (we_i && hit && off == OFF_PEND_CLR) ? wbits : '0;

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (off)
        OFF_EN:     rd_mux[N-1:0] = en_q;
        OFF_SENSE:  rd_mux[N-1:0] = sense_q;
        OFF_POL:    rd_mux[N-1:0] = pol_q;
        OFF_STATUS: rd_mux[N-1:0] = status_i;
        OFF_VECTOR: rd_mux        = vec_i;
        default:    rd_mux        = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign en_o    = en_q;
  assign sense_o = sense_q;
  assign pol_o   = pol_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 cascade_o
);
  logic [NUM_LINES-1:0] irq_sync, en_q, sense_q, pol_q, clr_vec, pend_q, status;
  logic [DATA_W-1:0]    vec_word;

  irq_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(irq_i), .sync_o(irq_sync)
  );

  irq_line_detect #(.N(NUM_LINES)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(irq_sync), .sense_i(sense_q),
    .pol_i(pol_q), .clr_i(clr_vec), .pend_o(pend_q)
  );

  assign status    = pend_q & en_q;   // R7
  assign cascade_o = |status;

  irq_prio_enc #(.N(NUM_LINES), .DATA_W(DATA_W)) u_prio (
    .status_i(status), .vec_o(vec_word)
  );

  irq_reg_file #(.N(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .status_i(status), .vec_i(vec_word), .en_o(en_q),
    .sense_o(sense_q), .pol_o(pol_q), .clr_o(clr_vec), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              cascade_o,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      sense_q,
  input logic [N-1:0]      pend_q,
  input logic [N-1:0]      clr_vec,
  input logic [DATA_W-1:0] vec_word
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  // R1
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_EN_SET)) |=>
      ((en_q & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));

  // R2
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_EN_CLR)) |=> ((en_q & $past(wdata_i[N-1:0])) == '0));

  // R7
  cascade_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_o == |(pend_q & en_q));

  // R6
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q & sense_q & ~clr_vec) & sense_q & ~pend_q) == '0));

  // R10
  vec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cascade_o |-> (vec_word == (DATA_W'(1) << (DATA_W - 1))));

  // R10
  vec_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_o |-> (!vec_word[DATA_W-1] && pend_q[vec_word[IDX_W-1:0]] && en_q[vec_word[IDX_W-1:0]]));
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(.N(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .cascade_o(cascade_o), .en_q(en_q), .sense_q(sense_q), .pend_q(pend_q),
  .clr_vec(clr_vec), .vec_word(vec_word)
);

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;
  localparam int unsigned NL = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam int unsigned NV = 6;
  localparam logic [31:0] NONE = 32'h8000_0000;

  localparam logic [31:0] TV_SENSE  [NV] = '{32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0};
  localparam logic [31:0] TV_POL    [NV] = '{32'h0, 32'hFFFF_0000, 32'h0, 32'hFFFF_FFFF, 32'h00FF_00FF, 32'h0};
  localparam logic [31:0] TV_EN     [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FF00, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h0};
  localparam logic [31:0] TV_BEFORE [NV] = '{32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0};
  localparam logic [31:0] TV_AFTER  [NV] = '{32'h0000_00F0, 32'h0F0F_0000, 32'h0001_2300, 32'h8000_0001, 32'hF0F0_F0F0, 32'hFFFF_FFFF};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] irq_i = '0;
  logic          we_i = 1'b0;
  logic          re_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          cascade_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_cascade_ctrl #(.NUM_LINES(NL), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .we_i(we_i), .re_i(re_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .cascade_o(cascade_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    re_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; irq_i = '0; we_i = 1'b0; re_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  function automatic logic [31:0] exp_pend(input logic [31:0] s, input logic [31:0] p,
                                           input logic [31:0] b, input logic [31:0] a);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (s[i]) r[i] = p[i] ? (b[i] & ~a[i]) : (~b[i] & a[i]);
      else      r[i] = a[i] ^ p[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_vec(input logic [31:0] st);
    for (int i = 0; i < 32; i++) if (st[i]) return 32'(i);
    return NONE;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, st;
    do_reset();

    // R12: reset state
    bus_read(4'd0, d); check("R12 mask", d, 32'h0);
    bus_read(4'd3, d); check("R12 sense", d, 32'h0);
    bus_read(4'd4, d); check("R12 polarity", d, 32'h0);
    bus_read(4'd6, d); check("R12 status", d, 32'h0);
    bus_read(4'd7, d); check("R12 vector", d, NONE);
    check("R12 cascade", 32'(cascade_o), 32'h0);

    // R1, R2, R3
    bus_write(4'd1, 32'h0000_00FF);
    bus_write(4'd1, 32'h0000_0F00);
    bus_read(4'd0, d); check("R1 set", d, 32'h0000_0FFF);
    bus_write(4'd2, 32'h0000_0081);
    bus_read(4'd0, d); check("R2 clear", d, 32'h0000_0F7E);
    bus_write(4'd0, 32'hFFFF_FFFF);
    bus_read(4'd0, d); check("R3 direct write ignored", d, 32'h0000_0F7E);

    // R4, R5 readback
    bus_write(4'd3, 32'h1234_5678);
    bus_read(4'd3, d); check("R4 sense readback", d, 32'h1234_5678);
    bus_write(4'd4, 32'h8765_4321);
    bus_read(4'd4, d); check("R5 polarity readback", d, 32'h8765_4321);

    // Table sweep: R4, R5, R7, R10
    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i); irq_i = TV_BEFORE[v];
      bus_write(4'd3, TV_SENSE[v]);
      bus_write(4'd4, TV_POL[v]);
      repeat (4) @(negedge clk_i);
      bus_write(4'd5, 32'hFFFF_FFFF);
      bus_write(4'd2, 32'hFFFF_FFFF);
      bus_write(4'd1, TV_EN[v]);
      @(negedge clk_i); irq_i = TV_AFTER[v];
      repeat (5) @(negedge clk_i);
      st = exp_pend(TV_SENSE[v], TV_POL[v], TV_BEFORE[v], TV_AFTER[v]) & TV_EN[v];
      bus_read(4'd6, d); check($sformatf("R7 status vec%0d (R4/R5 modes)", v), d, st);
      bus_read(4'd7, d); check($sformatf("R10 vector vec%0d", v), d, exp_vec(st));
      check($sformatf("R7 cascade vec%0d", v), 32'(cascade_o), 32'(st != 0));
    end

    // R8: latency through synchronizer, level-high line 0
    do_reset();
    bus_write(4'd1, 32'h0000_0001);
    @(negedge clk_i); irq_i[0] = 1'b1;
    @(negedge clk_i); check("R8 after 1 edge", 32'(cascade_o), 32'h0);
    @(negedge clk_i); check("R8 after 2 edges", 32'(cascade_o), 32'h0);
    @(negedge clk_i); check("R8 after 3 edges", 32'(cascade_o), 32'h1);

    // R9: clear does not drop an active level line
    bus_write(4'd5, 32'h0000_0001);
    bus_read(4'd6, d); check("R9 level survives clear", d, 32'h0000_0001);
    @(negedge clk_i); irq_i[0] = 1'b0;
    repeat (4) @(negedge clk_i);
    bus_read(4'd6, d); check("R9 level follows input", d, 32'h0);

    // R11: edge and clear in same cycle, line 1 rising
    bus_write(4'd3, 32'h0000_0002);
    bus_write(4'd1, 32'h0000_0002);
    bus_write(4'd5, 32'h0000_0002);
    bus_read(4'd6, d); check("R11 precondition idle", d, 32'h0);
    @(negedge clk_i); irq_i[1] = 1'b1;
    @(negedge clk_i);
    bus_write(4'd5, 32'h0000_0002);
    bus_read(4'd6, d); check("R11 edge wins over clear", d, 32'h0000_0002);

    // R6: held until cleared
    repeat (10) @(negedge clk_i);
    @(negedge clk_i); irq_i[1] = 1'b0;
    repeat (5) @(negedge clk_i);
    bus_read(4'd6, d); check("R6 edge latched after idle", d, 32'h0000_0002);
    bus_write(4'd5, 32'h0000_0002);
    bus_read(4'd6, d); check("R6 cleared", d, 32'h0);
    check("R6 cascade low", 32'(cascade_o), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule